// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between a group of general-purpose input pins that share one external interrupt vector and the interrupt controller. Each pin has its own interrupt-enable bit. Every enabled pin feeds one wired-AND source; a disabled pin is forced high so it cannot take part. The combined source passes through a synchronizer and a selectable detector: low level, rising edge, falling edge or both edges. The detector drives one request toward the controller.

An edge-detected request is held in a latch until the controller signals entry into the matching service routine. No software clear is involved. In low-level mode the request follows the synchronized level and nothing is stored. Because the pins are ANDed before detection, one enabled pin held low keeps the source low. A rising edge then cannot occur while that pin stays low. A separate wake output is formed from the raw combined source, ahead of the synchronizer. It can therefore bring the core out of a halt state in which the clock is stopped.

Top module: `ext_irq_conditioner`

## Requirements
- R1: While `rstN` is low, and after its release with all pins high, `irqReq` and `wakeOut` are 0.
- R2: The combined source is the AND of all pins whose `pinIntEn` bit is 1. A pin with a 0 enable bit counts as 1. With no pin enabled, the source is constantly high.
- R3: With `sensSel` = 2'b01 (rising edge only), a 0-to-1 change of the combined source raises `irqReq` after the third rising clock edge that follows the change. A 1-to-0 change raises nothing.
- R4: With `sensSel` = 2'b10 (falling edge only), a 1-to-0 change of the combined source raises `irqReq` with the same three-edge latency. A 0-to-1 change raises nothing.
- R5: With `sensSel` = 2'b11, both directions of change raise `irqReq` with the same three-edge latency.
- R6: With `sensSel` = 2'b00, `irqReq` is the inverse of the combined source delayed by two clock edges. It is not latched and falls as soon as the synchronized source returns high.
- R7: In the edge modes, a raised `irqReq` stays high until `svcEntry` is sampled high on a clock edge. It is 0 after that edge.
- R8: If a new qualifying edge is detected on the same clock edge at which `svcEntry` is high, the new request wins and `irqReq` is 1 after that edge.
- R9: While an enabled pin is held low, changes on other pins produce no request in rising-edge mode.
- R10: `wakeOut` is high whenever `irqReq` is high. It also rises combinationally, with no clock edge, when the raw combined source differs from the synchronized source in the selected edge direction. In mode 2'b00 it rises combinationally while the raw source is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Raw input pin levels |
| pinIntEn | input | NUM_PINS | Per-pin interrupt enable |
| sensSel | input | 2 | Sensitivity: 00 low level, 01 rising, 10 falling, 11 both |
| svcEntry | input | 1 | Controller strobe marking entry into the service routine |
| irqReq | output | 1 | Request toward the interrupt controller |
| wakeOut | output | 1 | Wake indication for leaving halt |

## Verification
The hardest situation to reach from the ports is a service-entry strobe landing on the very edge where a new edge is detected. The strobe has to be timed exactly two clock edges after the pin change, before any request is visible. The stimulus table places the strobe on that cycle in both-edges mode and checks that the request survives. The masking case is reached by holding one enabled pin low while others toggle. The request then appears only when that pin's enable is withdrawn.

// File: rtl/eic_pkg.sv
package eic_pkg;

  typedef enum logic [1:0] {
    SENS_LOW  = 2'b00,
    SENS_RISE = 2'b01,
    SENS_FALL = 2'b10,
    SENS_BOTH = 2'b11
  } sens_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic levelMode;
    logic wakeRise;
    logic wakeFall;
    logic wakeLow;
  } ctrl_stb_t;

endpackage

// File: rtl/eic_datapath.sv
module eic_datapath
  import eic_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinIntEn,
  input  ctrl_stb_t           stb,
  output logic                riseSeen,
  output logic                fallSeen,
  output logic                irqReq,
  output logic                wakeOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0]    maskedPins;
  logic                   rawSrc;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLevel;
  logic                   prevLevel;
  logic                   reqLatch;
  logic                   asyncWake;

  // disabled pins are forced to 1 so they cannot pull the AND low
  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_mask
      assign maskedPins[g] = pinIn[g] | ~pinIntEn[g];
    end
  endgenerate

  assign rawSrc = &maskedPins;

  // synchronizer, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rawSrc};
    end
  end

  assign syncLevel = syncChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= 1'b1;
    end else begin
      prevLevel <= syncLevel;
    end
  end

  assign riseSeen = syncLevel & ~prevLevel;
  assign fallSeen = ~syncLevel & prevLevel;

  // request latch: a new edge outranks the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqLatch <= 1'b0;
    end else if (stb.setLatch) begin
      reqLatch <= 1'b1;
    end else if (stb.clrLatch) begin
      reqLatch <= 1'b0;
    end
  end

  always_comb begin
    if (stb.levelMode) begin
      irqReq = ~syncLevel;
    end else begin
      irqReq = reqLatch;
    end
  end

  // wake is taken from the raw source, ahead of the synchronizer
  always_comb begin
    asyncWake = 1'b0;
    if (stb.wakeLow && !rawSrc) begin
      asyncWake = 1'b1;
    end
    if (stb.wakeRise && rawSrc && !syncLevel) begin
      asyncWake = 1'b1;
    end
    if (stb.wakeFall && !rawSrc && syncLevel) begin
      asyncWake = 1'b1;
    end
  end

  assign wakeOut = asyncWake | irqReq;

endmodule

// File: rtl/eic_control.sv
module eic_control
  import eic_pkg::*;
(
  input  logic       riseSeen,
  input  logic       fallSeen,
  input  logic [1:0] sensSel,
  input  logic       svcEntry,
  output ctrl_stb_t  stb
);

  sens_e mode;
  logic  edgeHit;

  assign mode = sens_e'(sensSel);

  always_comb begin
    stb      = '0;
    edgeHit  = 1'b0;
    unique case (mode)
      SENS_LOW: begin
        stb.levelMode = 1'b1;
        stb.wakeLow   = 1'b1;
      end
      SENS_RISE: begin
        edgeHit      = riseSeen;
        stb.wakeRise = 1'b1;
      end
      SENS_FALL: begin
        edgeHit      = fallSeen;
        stb.wakeFall = 1'b1;
      end
      SENS_BOTH: begin
        edgeHit      = riseSeen | fallSeen;
        stb.wakeRise = 1'b1;
        stb.wakeFall = 1'b1;
      end
      default: begin
        edgeHit = 1'b0;
      end
    endcase
    stb.setLatch = edgeHit;
    // level mode keeps nothing stored
    stb.clrLatch = svcEntry | stb.levelMode;
  end

endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
  import eic_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinIntEn,
  input  logic [1:0]          sensSel,
  input  logic                svcEntry,
  output logic                irqReq,
  output logic                wakeOut
);

  ctrl_stb_t ctrlStb;
  logic      riseSeen;
  logic      fallSeen;
  logic      latchSet;

  eic_control u_ctrl (
    .riseSeen (riseSeen),
    .fallSeen (fallSeen),
    .sensSel  (sensSel),
    .svcEntry (svcEntry),
    .stb      (ctrlStb)
  );

  eic_datapath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .pinIntEn (pinIntEn),
    .stb      (ctrlStb),
    .riseSeen (riseSeen),
    .fallSeen (fallSeen),
    .irqReq   (irqReq),
    .wakeOut  (wakeOut)
  );

  assign latchSet = ctrlStb.setLatch;

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinIn,
  input logic [NUM_PINS-1:0] pinIntEn,
  input logic [1:0]          sensSel,
  input logic                svcEntry,
  input logic                irqReq,
  input logic                wakeOut,
  input logic                latchSet
);

  logic [1:0] sinceRst;
  logic       combSrc;

  assign combSrc = &(pinIn | ~pinIntEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
    end else if (sinceRst != 2'd3) begin
      sinceRst <= sinceRst + 2'd1;
    end
  end

  p_level_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sensSel == 2'b00 && sinceRst == 2'd3) |-> (irqReq == !$past(combSrc, 2)));

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && sensSel != 2'b00 && !svcEntry) |=> (irqReq || sensSel == 2'b00));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (svcEntry && sensSel != 2'b00 && !latchSet) |=> (!irqReq || sensSel == 2'b00));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (svcEntry && latchSet && sensSel != 2'b00) |=> (irqReq || sensSel == 2'b00));

  p_wake_covers_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> wakeOut);

endmodule

bind ext_irq_conditioner eic_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pinIn    (pinIn),
  .pinIntEn (pinIntEn),
  .sensSel  (sensSel),
  .svcEntry (svcEntry),
  .irqReq   (irqReq),
  .wakeOut  (wakeOut),
  .latchSet (latchSet)
);

// File: tb/ext_irq_conditioner_tb_top.sv
module ext_irq_conditioner_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 4;
  localparam int NVEC       = 43;

  typedef struct packed {
    logic [3:0] pins;
    logic [3:0] en;
    logic [1:0] sens;
    logic       ack;
    logic       expReq;
    logic       expWake;
  } vec_t;

  // one row per clock cycle; inputs applied at the falling edge, outputs checked 1 ns later
  localparam vec_t VECS [NVEC] = '{
    '{4'hF, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 0  R3 idle
    '{4'hE, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 1  R3 source falls, no request
    '{4'hF, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 2  R3 source rises
    '{4'hF, 4'hF, 2'b01, 1'b0, 1'b0, 1'b1}, // 3  R10 wake ahead of request
    '{4'hF, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 4
    '{4'hF, 4'hF, 2'b01, 1'b0, 1'b1, 1'b1}, // 5  R3 request after three edges
    '{4'hF, 4'hF, 2'b01, 1'b1, 1'b1, 1'b1}, // 6  R7 held until ack edge
    '{4'hF, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 7  R7 cleared
    '{4'hE, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 8  R9 pin0 low masks
    '{4'hC, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 9  R9
    '{4'hE, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 10 R9 pin1 rises, masked
    '{4'hE, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 11 R9
    '{4'hE, 4'hF, 2'b01, 1'b0, 1'b0, 1'b0}, // 12 R9
    '{4'hE, 4'hE, 2'b01, 1'b0, 1'b0, 1'b1}, // 13 R2 disabling pin0 lifts source
    '{4'hE, 4'hE, 2'b01, 1'b0, 1'b0, 1'b1}, // 14 R10
    '{4'hE, 4'hE, 2'b01, 1'b0, 1'b0, 1'b0}, // 15
    '{4'hE, 4'hE, 2'b01, 1'b0, 1'b1, 1'b1}, // 16 R2 request
    '{4'hE, 4'hE, 2'b01, 1'b1, 1'b1, 1'b1}, // 17 R7
    '{4'hE, 4'hE, 2'b01, 1'b0, 1'b0, 1'b0}, // 18 R7
    '{4'hF, 4'hF, 2'b10, 1'b0, 1'b0, 1'b0}, // 19 R4 idle
    '{4'h7, 4'hF, 2'b10, 1'b0, 1'b0, 1'b1}, // 20 R10 wake without clock
    '{4'h7, 4'hF, 2'b10, 1'b0, 1'b0, 1'b1}, // 21
    '{4'h7, 4'hF, 2'b10, 1'b0, 1'b0, 1'b0}, // 22
    '{4'h7, 4'hF, 2'b10, 1'b0, 1'b1, 1'b1}, // 23 R4 request
    '{4'h7, 4'hF, 2'b10, 1'b1, 1'b1, 1'b1}, // 24 R7
    '{4'h7, 4'hF, 2'b10, 1'b0, 1'b0, 1'b0}, // 25 R7
    '{4'hF, 4'hF, 2'b11, 1'b0, 1'b0, 1'b1}, // 26 R5 rise
    '{4'hF, 4'hF, 2'b11, 1'b0, 1'b0, 1'b1}, // 27
    '{4'hF, 4'hF, 2'b11, 1'b1, 1'b0, 1'b0}, // 28 R8 ack on detect edge
    '{4'hF, 4'hF, 2'b11, 1'b0, 1'b1, 1'b1}, // 29 R8 new request survives
    '{4'hF, 4'hF, 2'b11, 1'b1, 1'b1, 1'b1}, // 30 R7
    '{4'hF, 4'hF, 2'b11, 1'b0, 1'b0, 1'b0}, // 31
    '{4'h7, 4'hF, 2'b11, 1'b0, 1'b0, 1'b1}, // 32 R5 fall
    '{4'h7, 4'hF, 2'b11, 1'b0, 1'b0, 1'b1}, // 33
    '{4'h7, 4'hF, 2'b11, 1'b0, 1'b0, 1'b0}, // 34
    '{4'h7, 4'hF, 2'b11, 1'b0, 1'b1, 1'b1}, // 35 R5 request on fall
    '{4'h7, 4'hF, 2'b11, 1'b1, 1'b1, 1'b1}, // 36
    '{4'h7, 4'hF, 2'b11, 1'b0, 1'b0, 1'b0}, // 37
    '{4'h7, 4'hF, 2'b00, 1'b0, 1'b1, 1'b1}, // 38 R6 low level
    '{4'hF, 4'hF, 2'b00, 1'b0, 1'b1, 1'b1}, // 39 R6
    '{4'hF, 4'hF, 2'b00, 1'b0, 1'b1, 1'b1}, // 40 R6
    '{4'hF, 4'hF, 2'b00, 1'b0, 1'b0, 1'b0}, // 41 R6 not latched
    '{4'hF, 4'hF, 2'b00, 1'b0, 1'b0, 1'b0}  // 42 R6
  };

  logic             clk;
  logic             rstN;
  logic [NPINS-1:0] pinIn;
  logic [NPINS-1:0] pinIntEn;
  logic [1:0]       sensSel;
  logic             svcEntry;
  logic             irqReq;
  logic             wakeOut;

  int checks;
  int errors;

  ext_irq_conditioner #(.NUM_PINS(NPINS), .SYNC_STAGES(2)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .pinIntEn (pinIntEn),
    .sensSel  (sensSel),
    .svcEntry (svcEntry),
    .irqReq   (irqReq),
    .wakeOut  (wakeOut)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired, all requirements");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks   = 0;
    errors   = 0;
    rstN     = 1'b0;
    pinIn    = 4'hF;
    pinIntEn = 4'hF;
    sensSel  = 2'b01;
    svcEntry = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", "irqReq in reset", irqReq, 1'b0);
    check("R1", "wakeOut in reset", wakeOut, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (i != 0) @(negedge clk);
      pinIn    = VECS[i].pins;
      pinIntEn = VECS[i].en;
      sensSel  = VECS[i].sens;
      svcEntry = VECS[i].ack;
      #1;
      check($sformatf("row%0d R3-R10", i), "irqReq", irqReq, VECS[i].expReq);
      check($sformatf("row%0d R10", i), "wakeOut", wakeOut, VECS[i].expWake);
    end

    // R2: no enabled pin means a constant high source, even with pins low in level mode
    @(negedge clk);
    pinIntEn = 4'h0;
    pinIn    = 4'h0;
    sensSel  = 2'b00;
    svcEntry = 1'b0;
    #1;
    check("R2", "wakeOut all disabled", wakeOut, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    check("R2", "irqReq all disabled", irqReq, 1'b0);

    // R1: reset during an active low-level request
    @(negedge clk);
    pinIntEn = 4'hF;
    repeat (3) @(negedge clk);
    #1;
    check("R6", "irqReq level active", irqReq, 1'b1);
    pinIn = 4'hF;
    rstN  = 1'b0;
    #1;
    check("R1", "irqReq on reset", irqReq, 1'b0);
    check("R1", "wakeOut on reset", wakeOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "irqReq after release", irqReq, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule